// File: doc/BRIEF.md
# Resize Increment and Filter Selector

This block turns a source size and a destination size into the step a scaler takes through the source for each output pixel. The step is unsigned fixed point with 10 fraction bits and 16 bits in all, so 1024 means one to one. Both axes are divided at the same time by a bit-serial divider. The block then applies two adjustments. A field taken from an interlaced source halves the vertical step. A chroma plane that is resampled between 4:2:0 and full-resolution layouts doubles or halves both steps.

For each adjusted step the block looks up a filter table index in a small programmable table of half-open ranges. There is one table for the horizontal axis and one for the vertical axis. Software loads the ranges once, then pulses `start` for each operation. It waits for the one-cycle `done` pulse and reads the increments, the scale flag, the two table indices and the error flag. These outputs stay unchanged until the next job completes.

Top module: `rsz_inc_sel`

## Requirements
- R1: Each axis increment equals floor(from * 1024 / to), where from and to are the source and destination sizes, and is reported as a 16-bit unsigned value with 10 fraction bits.
- R2: A job is in error when either destination size is zero, or when either quotient is zero or above 65535. In that case `err` is 1 and both increments, `scale_on` and both selections read zero. Otherwise `err` is 0.
- R3: When `interlaced` is 1, the vertical increment is halved, rounding down, after the division.
- R4: `scale_on` is 1 when the horizontal increment or the interlace-adjusted vertical increment differs from 1024. It is evaluated before any chroma adjustment.
- R5: When `chroma_plane` is 1, `src_420` is 0 and `dst_420` is 1, both increments are doubled modulo 65536. When `src_420` is 1 and `dst_420` is 0, both are halved, rounding down, whatever the plane. The reported increments and the selections use the adjusted values.
- R6: Each selection is the highest index i of 1 or more whose table entry satisfies min < inc <= max. If no entry matches, the selection is 0. Entry 0 is never tested. The horizontal axis uses table 0 and the vertical axis uses table 1.
- R7: A table write with `tbl_we` high stores `tbl_min` and `tbl_max` at entry `tbl_idx` of the table chosen by `tbl_vert` (0 horizontal, 1 vertical). Reset clears every entry to zero. A write on the same edge that completes a job is not seen by that job's selections.
- R8: `done` is high for exactly one cycle. It rises after the 27th rising edge (DIM_W+FRAC+1) that follows the edge sampling `start`, and `busy` is high from the edge after start until that completion edge.
- R9: Sizes and flags are captured when `start` is sampled while idle. A `start` while busy is ignored. All results read zero after reset and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job when idle |
| src_w | input | DIM_W | Source width |
| src_h | input | DIM_W | Source height |
| dst_w | input | DIM_W | Destination width |
| dst_h | input | DIM_W | Destination height |
| interlaced | input | 1 | Source is a single field of an interlaced frame |
| src_420 | input | 1 | Source chroma is 4:2:0 subsampled |
| dst_420 | input | 1 | Destination chroma is 4:2:0 subsampled |
| chroma_plane | input | 1 | The job targets the chroma plane |
| tbl_we | input | 1 | Range table write strobe |
| tbl_vert | input | 1 | Table select: 0 horizontal, 1 vertical |
| tbl_idx | input | IDX_W | Entry written |
| tbl_min | input | INC_W | Exclusive lower bound of the entry |
| tbl_max | input | INC_W | Inclusive upper bound of the entry |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| h_inc | output | INC_W | Horizontal increment |
| v_inc | output | INC_W | Vertical increment |
| scale_on | output | 1 | Scaling active |
| h_sel | output | IDX_W | Horizontal filter table index |
| v_sel | output | IDX_W | Vertical filter table index |
| err | output | 1 | Job rejected |

## Verification
A range table write and a job completion can fall on the same clock edge. On that edge the new entry is being stored while the selection is registered from the table. The bench lines a write up with the completion edge by counting negative edges from the start edge. It overwrites the entry that the running job is expected to pick and checks that the result still carries the old index. The next job must then see the new contents. A start pulse issued in the middle of a running job is the second overlap: the bench judges it by the finished result, which must come from the first job's inputs.

// File: rtl/rsz_inc_sel.sv
module rsz_inc_sel #(
  parameter int DIM_W = 16,
  parameter int FRAC  = 10,
  parameter int INC_W = 16,
  parameter int NTAB  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] src_w,
  input  logic [DIM_W-1:0] src_h,
  input  logic [DIM_W-1:0] dst_w,
  input  logic [DIM_W-1:0] dst_h,
  input  logic             interlaced,
  input  logic             src_420,
  input  logic             dst_420,
  input  logic             chroma_plane,
  input  logic             tbl_we,
  input  logic             tbl_vert,
  input  logic [$clog2(NTAB)-1:0] tbl_idx,
  input  logic [INC_W-1:0] tbl_min,
  input  logic [INC_W-1:0] tbl_max,
  output logic             busy,
  output logic             done,
  output logic [INC_W-1:0] h_inc,
  output logic [INC_W-1:0] v_inc,
  output logic             scale_on,
  output logic [$clog2(NTAB)-1:0] h_sel,
  output logic [$clog2(NTAB)-1:0] v_sel,
  output logic             err
);
  localparam int IDX_W = $clog2(NTAB);
  localparam int QW    = DIM_W + FRAC;
  localparam int CW    = $clog2(QW + 1);
  localparam logic [INC_W-1:0] UNITY = INC_W'(1 << FRAC);

  logic [INC_W-1:0] tmin [2][NTAB];
  logic [INC_W-1:0] tmax [2][NTAB];

  logic [CW-1:0] cnt;
  logic ilq, s4q, d4q, chq;
  logic [1:0] bad;
  logic [1:0][INC_W-1:0] raw, adj;
  logic [1:0][IDX_W-1:0] pick;
  logic [INC_W-1:0] vi;
  logic scl, dn, up, go;

  assign go = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < NTAB; i++) begin
          tmin[t][i] <= '0;
          tmax[t][i] <= '0;
        end
    end else if (tbl_we) begin
      tmin[tbl_vert][tbl_idx] <= tbl_min;
      tmax[tbl_vert][tbl_idx] <= tbl_max;
    end
  end

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    logic [DIM_W-1:0] from, to, dvs;
    logic [DIM_W:0]   rem, shl;
    logic [QW-1:0]    quo;

    assign from = ax ? src_h : src_w;
    assign to   = ax ? dst_h : dst_w;
    assign shl  = {rem[DIM_W-1:0], quo[QW-1]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rem <= '0;
        quo <= '0;
        dvs <= '0;
      end else if (go) begin
        rem <= '0;
        quo <= {from, {FRAC{1'b0}}};
        dvs <= to;
      end else if (busy && cnt != '0) begin
        if (shl >= {1'b0, dvs}) begin
          rem <= shl - {1'b0, dvs};
          quo <= {quo[QW-2:0], 1'b1};
        end else begin
          rem <= shl;
          quo <= {quo[QW-2:0], 1'b0};
        end
      end
    end

    assign raw[ax] = quo[INC_W-1:0];
    assign bad[ax] = (dvs == '0) || (quo == '0) || (quo[QW-1:INC_W] != '0);

    always_comb begin
      pick[ax] = '0;
      for (int i = 1; i < NTAB; i++)
        if (tmin[ax][i] < adj[ax] && adj[ax] <= tmax[ax][i])
          pick[ax] = IDX_W'(i);
    end
  end

  assign vi  = ilq ? (raw[1] >> 1) : raw[1];
  assign scl = (raw[0] != UNITY) || (vi != UNITY);
  assign dn  = chq && !s4q && d4q;
  assign up  = s4q && !d4q;
  assign adj[0] = dn ? (raw[0] << 1) : up ? (raw[0] >> 1) : raw[0];
  assign adj[1] = dn ? (vi << 1) : up ? (vi >> 1) : vi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0;
      ilq <= 1'b0; s4q <= 1'b0; d4q <= 1'b0; chq <= 1'b0;
      h_inc <= '0; v_inc <= '0; scale_on <= 1'b0;
      h_sel <= '0; v_sel <= '0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        cnt  <= CW'(QW);
        ilq  <= interlaced;
        s4q  <= src_420;
        d4q  <= dst_420;
        chq  <= chroma_plane;
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
          err  <= |bad;
          if (|bad) begin
            h_inc <= '0; v_inc <= '0; scale_on <= 1'b0;
            h_sel <= '0; v_sel <= '0;
          end else begin
            h_inc <= adj[0]; v_inc <= adj[1]; scale_on <= scl;
            h_sel <= pick[0]; v_sel <= pick[1];
          end
        end
      end
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);

  a_r2_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> h_inc == '0 && v_inc == '0 && !scale_on && h_sel == '0 && v_sel == '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(h_inc) && $stable(v_inc) && $stable(err) && $stable(h_sel) && $stable(v_sel));

  a_r6_hsel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && !$past(tbl_we) |->
      (h_sel == '0) || (tmin[0][h_sel] < h_inc && h_inc <= tmax[0][h_sel]));

  a_r6_vsel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && !$past(tbl_we) |->
      (v_sel == '0) || (tmin[1][v_sel] < v_inc && v_inc <= tmax[1][v_sel]));
endmodule

// File: tb/rsz_inc_sel_tb.sv
module rsz_inc_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 28;

  typedef struct packed {
    logic [15:0] sw, sh, dw, dh;
    logic il, s4, d4, ch;
    logic [15:0] eh, ev;
    logic esc;
    logic [2:0] ehs, evs;
    logic eerr;
    logic [3:0] tag;
  } vec_t;

  localparam vec_t VECS [0:14] = '{
    '{100,100,100,100, 0,0,0,0, 1024,1024, 0, 1,1, 0, 1},   // R1 unity
    '{200,100,100, 50, 0,0,0,0, 2048,2048, 1, 2,5, 0, 1},   // R1 R6 downscale
    '{300,100,200,300, 0,0,0,0, 1536, 341, 1, 3,0, 0, 6},   // R6 overlap priority, fallback
    '{100,100,100,100, 1,0,0,0, 1024, 512, 1, 1,0, 0, 3},   // R3 interlace
    '{100,100,100,100, 0,0,1,1, 2048,2048, 0, 2,5, 0, 5},   // R5 chroma down, R4 pre-adjust
    '{100,100,100,100, 0,0,1,0, 1024,1024, 0, 1,1, 0, 5},   // R5 luma plane untouched
    '{200,200,100,100, 0,1,0,0, 1024,1024, 1, 1,1, 0, 5},   // R5 upsample
    '{100,100,  0,100, 0,0,0,0,    0,   0, 0, 0,0, 1, 2},   // R2 zero output
    '{ 64,100,  1,100, 0,0,0,0,    0,   0, 0, 0,0, 1, 2},   // R2 overflow
    '{ 63,  1,  1,  1, 0,0,0,0, 64512,1024, 1, 0,1, 0, 2},  // R2 largest legal
    '{  0,100,100,100, 0,0,0,0,    0,   0, 0, 0,0, 1, 2},   // R2 zero quotient
    '{  1,100,1024,100,0,0,0,0,    1,1024, 1, 1,1, 0, 1},   // R1 smallest
    '{625,100, 16,100, 0,0,1,1, 14464,2048, 1, 0,5, 0, 5},  // R5 doubling wraps
    '{100,100,100,100, 1,1,0,0,  512, 256, 1, 1,0, 0, 4},   // R4 R3 R5 combined
    '{100,  3,100,  2, 1,0,0,0, 1024, 768, 1, 1,1, 0, 3}    // R3 floor halving
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic interlaced = 1'b0, src_420 = 1'b0, dst_420 = 1'b0, chroma_plane = 1'b0;
  logic tbl_we = 1'b0, tbl_vert = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [15:0] tbl_min = '0, tbl_max = '0;
  logic busy, done, scale_on, err;
  logic [15:0] h_inc, v_inc;
  logic [2:0] h_sel, v_sel;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsz_inc_sel dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .interlaced(interlaced), .src_420(src_420), .dst_420(dst_420),
    .chroma_plane(chroma_plane),
    .tbl_we(tbl_we), .tbl_vert(tbl_vert), .tbl_idx(tbl_idx),
    .tbl_min(tbl_min), .tbl_max(tbl_max),
    .busy(busy), .done(done), .h_inc(h_inc), .v_inc(v_inc),
    .scale_on(scale_on), .h_sel(h_sel), .v_sel(v_sel), .err(err)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic v, input int idx, input int mn, input int mx);
    @(negedge clk);
    tbl_we = 1'b1; tbl_vert = v; tbl_idx = 3'(idx);
    tbl_min = 16'(mn); tbl_max = 16'(mx);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_tables;
    wr(0, 1, 0, 1024);
    wr(0, 2, 1024, 2048);
    wr(0, 3, 1500, 1800);
    wr(1, 1, 512, 1024);
    wr(1, 5, 1024, 4096);
  endtask

  task automatic set_in(input vec_t v);
    src_w = v.sw; src_h = v.sh; dst_w = v.dw; dst_h = v.dh;
    interlaced = v.il; src_420 = v.s4; dst_420 = v.d4; chroma_plane = v.ch;
  endtask

  // leaves the bench at the first negedge after the start-sampling edge (k = 1)
  task automatic launch(input vec_t v);
    @(negedge clk);
    set_in(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 1;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 done timeout actual=%0d expected=%0d", k, LAT);
    end
  endtask

  task automatic check_result(input vec_t v, input string rq);
    chk(rq, "h_inc", h_inc, v.eh);
    chk(rq, "v_inc", v_inc, v.ev);
    chk("R4", "scale_on", scale_on, v.esc);
    chk("R6", "h_sel", h_sel, v.ehs);
    chk("R6", "v_sel", v_sel, v.evs);
    chk("R2", "err", err, v.eerr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    vec_t v;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "busy after reset", busy, 0);
    chk("R9", "done after reset", done, 0);
    chk("R9", "h_inc after reset", h_inc, 0);
    chk("R9", "err after reset", err, 0);
    rst_n = 1'b1;
    load_tables();

    for (int i = 0; i < 15; i++) begin
      launch(VECS[i]);
      wait_done(k);
      check_result(VECS[i], $sformatf("R%0d vec%0d", VECS[i].tag, i));
    end

    // R8 latency and single pulse
    launch(VECS[1]);
    chk("R8", "busy while dividing", busy, 1);
    wait_done(k);
    chk("R8", "done latency", k, LAT);
    @(negedge clk);
    chk("R8", "done width", done, 0);
    chk("R8", "busy after done", busy, 0);

    // R9 outputs hold after inputs change
    set_in(VECS[0]);
    repeat (5) @(negedge clk);
    chk("R9", "h_inc held", h_inc, 2048);
    chk("R9", "v_sel held", v_sel, 5);

    // R9 start while busy ignored
    launch(VECS[1]);
    repeat (4) @(negedge clk);
    set_in(VECS[7]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(k);
    chk("R9", "busy start ignored h_inc", h_inc, 2048);
    chk("R9", "busy start ignored err", err, 0);
    @(negedge clk);
    chk("R9", "no second job", busy, 0);

    // R7 write coinciding with the completion edge is not seen
    launch(VECS[1]);
    repeat (26) @(negedge clk);
    tbl_we = 1'b1; tbl_vert = 1'b0; tbl_idx = 3'd2; tbl_min = '0; tbl_max = '0;
    @(negedge clk);
    tbl_we = 1'b0;
    chk("R7", "done at completion edge", done, 1);
    chk("R7", "old entry used at write edge", h_sel, 2);
    launch(VECS[1]);
    wait_done(k);
    chk("R7", "new entry used next job", h_sel, 0);

    // R7 reset clears tables
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    v = VECS[0];
    launch(v);
    wait_done(k);
    chk("R7", "cleared table h_sel", h_sel, 0);
    chk("R7", "cleared table v_sel", v_sel, 0);
    chk("R1", "h_inc after table reset", h_inc, 1024);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule